// File: doc/BRIEF.md
# Programmable-Phase Peripheral Access Sequencer

This block converts one host read or write request into a timed strobe cycle on an external 8-bit or 16-bit peripheral bus. Every access runs through three successive phases. The first phase is setup, the second is the strobe and the third is hold. Software sets the length of each phase in clock cycles. The strobe phase has one length for reads and a different length for writes. Chip select, the read strobe, the write strobe and a read-data latch pulse all come from the current phase. When the cycle finishes, the host sees a one-clock done pulse, with the read data valid in that same cycle.

The host keeps `req_i` high until `stall_o` is low on a clock edge. That edge accepts the request. The sequencer captures the direction, the write data and the configuration at acceptance. It uses those captured values for the whole cycle. A request is also held off while the associated DMA channel is marked active and its masking control is set. The lockout only delays the start of a cycle. A cycle that has already started runs to the end.

Top module: `pio_phase_seq`

## Requirements
- R1: Setup lasts `cfg_p1_i`+1 cycles, strobe lasts the selected strobe count +1 cycles, and hold lasts `cfg_p3_i`+1 cycles. A count of zero still takes one cycle. Setup begins in the cycle after the accepting edge.
- R2: A read uses `cfg_p2_rd_i` (4 bits) as the strobe count. A write uses `cfg_p2_wr_i` (3 bits). The field that belongs to the other direction has no effect.
- R3: `cs_o` is high from the first setup cycle to the last hold cycle. `rd_o` (reads) or `wr_o` (writes) is high only during the strobe phase. The two strobes are never high together, and neither is high while `cs_o` is low.
- R4: On a read, `latch_o` pulses in the last strobe cycle only. `bus_din_i` is captured at the end of that cycle and is shown on `rdata_o` from then on.
- R5: `done_o` is high for exactly one cycle, the cycle after the last hold cycle.
- R6: `stall_o` is high while `req_i` is high and a cycle is in progress. A held request is accepted on the edge that ends the done cycle, so its setup starts in the following cycle.
- R7: `stall_o` is high and no cycle starts while `req_i`, `dma_active_i` and `dma_mask_i` are all high. DMA activity with the mask clear does not stall.
- R8: When `cfg_half_i`=0 (8-bit mode), write data travels on `bus_dout_o[7:0]` with `bus_dout_o[15:8]`=0. A read keeps only `bus_din_i[7:0]`. When `cfg_half_i`=1, all 16 bits are used.
- R9: When `cfg_swap_i`=1, the two byte lanes are exchanged. For writes the swap happens before the 8-bit lane selection, so an 8-bit write of 0xBEEF drives 0x00BE. For reads the swap happens after the lane selection, so an 8-bit read of 0xA55A returns 0x5A00.
- R10: After reset, `cs_o`, `rd_o`, `wr_o`, `latch_o`, `done_o` and `stall_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until not stalled |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 16 | Host write data |
| stall_o | output | 1 | Request cannot be accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data for the host |
| cfg_p1_i | input | 3 | Setup phase count |
| cfg_p2_rd_i | input | 4 | Strobe phase count for reads |
| cfg_p2_wr_i | input | 3 | Strobe phase count for writes |
| cfg_p3_i | input | 2 | Hold phase count |
| cfg_half_i | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| cfg_swap_i | input | 1 | Exchange byte lanes |
| dma_active_i | input | 1 | Associated DMA channel is active |
| dma_mask_i | input | 1 | DMA activity blocks host accesses |
| cs_o | output | 1 | Peripheral chip select |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| latch_o | output | 1 | Read data capture pulse |
| bus_oe_o | output | 1 | Drive the peripheral data bus |
| bus_dout_o | output | 16 | Data driven to the peripheral |
| bus_din_i | input | 16 | Data returned by the peripheral |

## Verification
Some rules are checked by the assertions on every cycle. These are the countdown inside each phase, the strobes only appearing under chip select and never together, the latch pulse only appearing inside a read strobe, the done pulse following hold and lasting one cycle, and the stall under a masked DMA lockout. Only the bench scenarios can show the rest: the exact phase lengths for each count, the choice between the read and write strobe counts, the lane selection and swap order on data, and the precise restart edge of a held request.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_STRB  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;
endpackage

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
  import pio_seq_pkg::*;
#(
  parameter int P1_W  = 3,
  parameter int P2R_W = 4,
  parameter int P2W_W = 3,
  parameter int P3_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             we_i,
  input  logic [P1_W-1:0]  p1_i,
  input  logic [P2R_W-1:0] p2r_i,
  input  logic [P2W_W-1:0] p2w_i,
  input  logic [P3_W-1:0]  p3_i,
  output phase_e           phase_o,
  output logic             last_o,
  output logic             we_o,
  output logic             done_o
);
  localparam int W12   = (P1_W > P2R_W) ? P1_W : P2R_W;
  localparam int W34   = (P2W_W > P3_W) ? P2W_W : P3_W;
  localparam int CNT_W = (W12 > W34) ? W12 : W34;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] p2_q;
  logic [P3_W-1:0]  p3_q;
  logic             we_q;
  logic             done_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      p2_q    <= '0;
      p3_q    <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= CNT_W'(p1_i);
          p2_q    <= we_i ? CNT_W'(p2w_i) : CNT_W'(p2r_i);
          p3_q    <= p3_i;
          we_q    <= we_i;
        end
        PH_SETUP: if (last) begin
          phase_q <= PH_STRB;
          cnt_q   <= p2_q;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_STRB: if (last) begin
          phase_q <= PH_HOLD;
          cnt_q   <= CNT_W'(p3_q);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_HOLD: if (last) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign last_o  = last;
  assign we_o    = we_q;
  assign done_o  = done_q;

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && cnt_q != '0) |=> (phase_q == $past(phase_q) && cnt_q == $past(cnt_q) - CNT_W'(1))); // R1
  AST_DONE_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && last) |=> done_q); // R5
  AST_DONE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> phase_q == PH_IDLE); // R6
endmodule

// File: rtl/pio_lane_fmt.sv
module pio_lane_fmt #(
  parameter int DATA_W = 16,
  parameter bit TO_BUS = 1'b1
) (
  input  logic              half_i,
  input  logic              swap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o
);
  localparam int LANE_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] swap_lanes(input logic [DATA_W-1:0] v);
    return {v[LANE_W-1:0], v[DATA_W-1:LANE_W]};
  endfunction

  function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] v);
    return {{(DATA_W-LANE_W){1'b0}}, v[LANE_W-1:0]};
  endfunction

  generate
    if (TO_BUS) begin : g_wr
      // swap first, then select low lane
      logic [DATA_W-1:0] sw;
      assign sw  = swap_i ? swap_lanes(d_i) : d_i;
      assign d_o = half_i ? sw : narrow(sw);
    end else begin : g_rd
      // select low lane first, then swap
      logic [DATA_W-1:0] nw;
      assign nw  = half_i ? d_i : narrow(d_i);
      assign d_o = swap_i ? swap_lanes(nw) : nw;
    end
  endgenerate
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int P1_W   = 3,
  parameter int P2R_W  = 4,
  parameter int P2W_W  = 3,
  parameter int P3_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              stall_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [P1_W-1:0]   cfg_p1_i,
  input  logic [P2R_W-1:0]  cfg_p2_rd_i,
  input  logic [P2W_W-1:0]  cfg_p2_wr_i,
  input  logic [P3_W-1:0]   cfg_p3_i,
  input  logic              cfg_half_i,
  input  logic              cfg_swap_i,
  input  logic              dma_active_i,
  input  logic              dma_mask_i,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              latch_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_dout_o,
  input  logic [DATA_W-1:0] bus_din_i
);
  phase_e            phase;
  logic              last, cyc_we, busy, lock, accept;
  logic              half_q, swap_q;
  logic [DATA_W-1:0] wfmt, rfmt, dout_q, rdata_q;

  assign busy    = (phase != PH_IDLE);
  assign lock    = dma_active_i & dma_mask_i;
  assign accept  = req_i & ~busy & ~lock;
  assign stall_o = req_i & (busy | lock);

  pio_phase_ctrl #(
    .P1_W(P1_W), .P2R_W(P2R_W), .P2W_W(P2W_W), .P3_W(P3_W)
  ) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .we_i    (we_i),
    .p1_i    (cfg_p1_i),
    .p2r_i   (cfg_p2_rd_i),
    .p2w_i   (cfg_p2_wr_i),
    .p3_i    (cfg_p3_i),
    .phase_o (phase),
    .last_o  (last),
    .we_o    (cyc_we),
    .done_o  (done_o)
  );

  pio_lane_fmt #(.DATA_W(DATA_W), .TO_BUS(1'b1)) i_wfmt (
    .half_i (cfg_half_i),
    .swap_i (cfg_swap_i),
    .d_i    (wdata_i),
    .d_o    (wfmt)
  );

  pio_lane_fmt #(.DATA_W(DATA_W), .TO_BUS(1'b0)) i_rfmt (
    .half_i (half_q),
    .swap_i (swap_q),
    .d_i    (bus_din_i),
    .d_o    (rfmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      swap_q  <= 1'b0;
      dout_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        half_q <= cfg_half_i;
        swap_q <= cfg_swap_i;
        dout_q <= wfmt;
      end
      if (latch_o) rdata_q <= rfmt;
    end
  end

  assign cs_o       = busy;
  assign rd_o       = (phase == PH_STRB) & ~cyc_we;
  assign wr_o       = (phase == PH_STRB) & cyc_we;
  assign latch_o    = rd_o & last;
  assign bus_oe_o   = busy & cyc_we;
  assign bus_dout_o = dout_q;
  assign rdata_o    = rdata_q;

  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> cs_o); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R3
  AST_LATCH_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> (rd_o && !wr_o)); // R4
  AST_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && dma_active_i && dma_mask_i) |-> stall_o); // R7
  AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cs_o) |-> stall_o); // R6
endmodule

// File: tb/test_pio_phase_seq.sv
module test_pio_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [15:0] wdata_i = '0, bus_din_i = '0;
  logic [2:0]  cfg_p1_i = '0, cfg_p2_wr_i = '0;
  logic [3:0]  cfg_p2_rd_i = '0;
  logic [1:0]  cfg_p3_i = '0;
  logic        cfg_half_i = 1'b0, cfg_swap_i = 1'b0;
  logic        dma_active_i = 1'b0, dma_mask_i = 1'b0;
  logic        stall_o, done_o, cs_o, rd_o, wr_o, latch_o, bus_oe_o;
  logic [15:0] rdata_o, bus_dout_o;

  int errors = 0, checks = 0, cyc = 0;

  pio_phase_seq i_pio_phase_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .wdata_i, .stall_o, .done_o, .rdata_o,
    .cfg_p1_i, .cfg_p2_rd_i, .cfg_p2_wr_i, .cfg_p3_i, .cfg_half_i, .cfg_swap_i,
    .dma_active_i, .dma_mask_i, .cs_o, .rd_o, .wr_o, .latch_o, .bus_oe_o,
    .bus_dout_o, .bus_din_i
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WDOG_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-access observations
  int cs_n, st_first, st_n, st_rd_n, latch_idx, latch_n, done_idx, stall_n;
  logic [15:0] dout_seen, rdata_seen;

  task automatic run_access(input logic we, input logic [15:0] wd, input logic [15:0] din);
    cs_n = 0; st_first = -1; st_n = 0; st_rd_n = 0; latch_idx = -1; latch_n = 0;
    done_idx = -1; stall_n = 0; dout_seen = '0; rdata_seen = '0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; wdata_i = wd; bus_din_i = din;
    #1;
    while (stall_o) begin stall_n++; @(negedge clk_i); #1; end
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    for (int idx = 0; idx < 100; idx++) begin
      if (idx > 0) @(negedge clk_i);
      if (cs_o) cs_n++;
      if (rd_o || wr_o) begin
        if (st_n == 0) st_first = idx;
        st_n++;
        if (rd_o) st_rd_n++;
        if (wr_o) dout_seen = bus_dout_o;
      end
      if (latch_o) begin latch_idx = idx; latch_n++; end
      if (done_o) begin done_idx = idx; rdata_seen = rdata_o; break; end
    end
  endtask

  task automatic check_timing(input int p1, input int p2, input int p3, input logic we, input string tag);
    int tot;
    tot = p1 + p2 + p3 + 3;
    check(cs_n == tot, {tag, " R1 R3 cs cycles"}, cs_n, tot);
    check(st_first == p1 + 1, {tag, " R1 strobe start"}, st_first, p1 + 1);
    check(st_n == p2 + 1, {tag, " R2 strobe length"}, st_n, p2 + 1);
    check(st_rd_n == (we ? 0 : p2 + 1), {tag, " R3 strobe type"}, st_rd_n, we ? 0 : p2 + 1);
    check(done_idx == tot, {tag, " R5 done position"}, done_idx, tot);
    if (!we) begin
      check(latch_n == 1 && latch_idx == p1 + p2 + 1, {tag, " R4 latch cycle"}, latch_idx, p1 + p2 + 1);
    end else begin
      check(latch_n == 0, {tag, " R4 no latch on write"}, latch_n, 0);
    end
  endtask

  task automatic set_cfg(input int p1, input int p2r, input int p2w, input int p3,
                         input logic half, input logic swap);
    cfg_p1_i = 3'(p1); cfg_p2_rd_i = 4'(p2r); cfg_p2_wr_i = 3'(p2w); cfg_p3_i = 2'(p3);
    cfg_half_i = half; cfg_swap_i = swap;
  endtask

  task automatic t_reset;
    #1;
    check({cs_o, rd_o, wr_o, latch_o, done_o, stall_o} == 6'b0, "R10 outputs in reset", 0, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check({cs_o, rd_o, wr_o, latch_o, done_o, stall_o} == 6'b0, "R10 idle after reset",
          {cs_o, rd_o, wr_o, latch_o, done_o, stall_o}, 0);
  endtask

  task automatic t_min_read;
    set_cfg(0, 0, 5, 0, 1'b0, 1'b0);
    run_access(1'b0, 16'h0, 16'hA55A);
    check_timing(0, 0, 0, 1'b0, "min read");
    check(rdata_seen == 16'h005A, "R8 8-bit read lane", rdata_seen, 16'h005A);
    check(rdata_o == 16'h005A, "R4 rdata held after done", rdata_o, 16'h005A);
  endtask

  task automatic t_max_read;
    set_cfg(7, 15, 1, 3, 1'b1, 1'b0);
    run_access(1'b0, 16'h0, 16'h1234);
    check_timing(7, 15, 3, 1'b0, "max read");
    check(rdata_seen == 16'h1234, "R8 16-bit read", rdata_seen, 16'h1234);
  endtask

  task automatic t_write_sel;
    set_cfg(2, 9, 4, 1, 1'b1, 1'b0);
    run_access(1'b1, 16'hBEEF, 16'h0);
    check_timing(2, 4, 1, 1'b1, "write p2w");
    check(dout_seen == 16'hBEEF, "R8 16-bit write data", dout_seen, 16'hBEEF);
    set_cfg(1, 0, 7, 2, 1'b0, 1'b0);
    run_access(1'b1, 16'hBEEF, 16'h0);
    check_timing(1, 7, 2, 1'b1, "write max p2w");
    check(dout_seen == 16'h00EF, "R8 8-bit write lane", dout_seen, 16'h00EF);
    set_cfg(3, 6, 0, 0, 1'b0, 1'b0);
    run_access(1'b0, 16'h0, 16'hFFC3);
    check_timing(3, 6, 0, 1'b0, "read ignores p2w");
  endtask

  task automatic t_swap;
    set_cfg(0, 1, 1, 0, 1'b0, 1'b1);
    run_access(1'b1, 16'hBEEF, 16'h0);
    check(dout_seen == 16'h00BE, "R9 8-bit write swap", dout_seen, 16'h00BE);
    run_access(1'b0, 16'h0, 16'hA55A);
    check(rdata_seen == 16'h5A00, "R9 8-bit read swap", rdata_seen, 16'h5A00);
    set_cfg(0, 1, 1, 0, 1'b1, 1'b1);
    run_access(1'b1, 16'hBEEF, 16'h0);
    check(dout_seen == 16'hEFBE, "R9 16-bit write swap", dout_seen, 16'hEFBE);
    run_access(1'b0, 16'h0, 16'h1234);
    check(rdata_seen == 16'h3412, "R9 16-bit read swap", rdata_seen, 16'h3412);
  endtask

  task automatic t_lockout;
    int bad;
    set_cfg(1, 1, 1, 1, 1'b1, 1'b0);
    dma_active_i = 1'b1; dma_mask_i = 1'b0;
    run_access(1'b0, 16'h0, 16'h0F0F);
    check(stall_n == 0, "R7 active without mask no stall", stall_n, 0);
    dma_mask_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; wdata_i = 16'h7777;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      #1;
      if (!stall_o || cs_o) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R7 locked out while masked", bad, 0);
    dma_active_i = 1'b0;
    run_access(1'b1, 16'h7777, 16'h0);
    check_timing(1, 1, 1, 1'b1, "after lockout");
    check(dout_seen == 16'h7777, "R7 held write completes", dout_seen, 16'h7777);
  endtask

  task automatic t_back_to_back;
    int tot, stall_cnt, free_idx, cs_start;
    set_cfg(1, 2, 0, 1, 1'b1, 1'b0);
    tot = 1 + 2 + 1 + 3;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; bus_din_i = 16'h4444;
    #1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b1; wdata_i = 16'hC0DE;
    stall_cnt = 0; free_idx = -1;
    for (int idx = 0; idx < 50; idx++) begin
      if (idx > 0) @(negedge clk_i);
      #1;
      if (stall_o) stall_cnt++;
      else begin free_idx = idx; break; end
    end
    check(stall_cnt == tot, "R6 stall while busy", stall_cnt, tot);
    check(free_idx == tot, "R6 accepted at done cycle", free_idx, tot);
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    cs_start = cs_o;
    check(cs_start == 1, "R6 second cycle starts next", cs_start, 1);
    dout_seen = '0;
    for (int i = 0; i < 50; i++) begin
      if (wr_o) dout_seen = bus_dout_o;
      if (done_o) break;
      @(negedge clk_i);
    end
    check(dout_seen == 16'hC0DE, "R6 held write data", dout_seen, 16'hC0DE);
  endtask

  initial begin
    t_reset();
    t_min_read();
    t_max_read();
    t_write_sel();
    t_swap();
    t_lockout();
    t_back_to_back();
    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule